// File: doc/BRIEF.md
# Paged GPIO Register File

This block is the host-facing register file of a 48-line general-purpose I/O peripheral. A host reaches it over a byte-wide bus: an 8-bit address, write data, a write strobe and a read strobe. Six data registers hold one byte each. A data bit written to 1 pulls its line low through an open-collector style driver. A data bit written to 0 releases the line, so the line can serve as an input. Reading a data offset returns the live pin levels, not the stored byte.

The first three ports (24 lines) can raise interrupts. The edge detection logic sits outside this block. For those ports, the block only stores and exports the polarity and enable bits, passes the captured interrupt-ID bits through for reading, and turns host writes to the ID bank into one-cycle clear pulses. These three banks share three addresses at the top of the map. A page field in a separate page register selects which bank those addresses reach. A read-only summary byte shows which of the three interrupt ports has any ID bit set.

Every access completes in the cycle it is presented, so the bus has no back-pressure and no handshake. A write lands on the next clock edge. Read data is combinational from the address.

Top module: `pgpio_regs`

## Requirements
- R1: After reset, pin_drive, irq_pol, irq_ena and irq_clr are all 0, and the page register reads 0x00.
- R2: A write to offset k (0 to 5) sets pin_drive[8k+7:8k] to wdata on the following clock edge. The other ports keep their values.
- R3: A read at offset k (0 to 5) returns pin_in[8k+7:8k], the live level, whatever value the data register holds.
- R4: Offset 0x6 reads bit p (p = 0..2) as the OR of irq_id_in[8p+7:8p], and bits 7:3 read as 0. Writes to 0x6 change no register.
- R5: Offset 0x7 reads back the full byte last written to it. Its bits 7:6 form the page field: 0 means none, 1 means polarity, 2 means enable, 3 means interrupt ID.
- R6: With page 1, offsets 0x8, 0x9 and 0xA read and write the polarity bytes of ports 0, 1 and 2. These bytes drive irq_pol[8p+7:8p].
- R7: With page 2, the same offsets read and write the enable bytes. These bytes drive irq_ena[8p+7:8p].
- R8: With page 3, a read at 0x8+p returns irq_id_in[8p+7:8p]. A write there raises irq_clr[8p+7:8p] = wdata for exactly the one cycle after the write edge.
- R9: With page 0, offsets 0x8 to 0xA read 0, and writes to them change neither polarity nor enable and raise no clear pulse.
- R10: Offsets above 0xA read 0, and writes to them change no register.
- R11: rdata is 0 whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Combinational read data |
| pin_in | input | 48 | Live pin levels |
| pin_drive | output | 48 | Pull-low enables, one per line |
| irq_id_in | input | 24 | Captured interrupt-ID bits from the edge logic |
| irq_pol | output | 24 | Polarity bits, 1 = rising edge |
| irq_ena | output | 24 | Interrupt enable bits |
| irq_clr | output | 24 | One-cycle clear pulses toward the edge logic |

## Verification
The hardest case to reach is a write to the shared window that lands on the wrong bank. This can happen after the page changes, or while page 0 is selected. Polarity and enable bits that are not selected at the time cannot be seen directly from the window. The stimulus therefore loads distinct patterns into both banks, moves the page to 0 and to 3, and writes the window. It then pages back to check that neither stored pattern moved, and watches irq_pol, irq_ena and irq_clr on every step. The clear pulse is sampled in the single cycle after its write edge and again one cycle later.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;
  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_ENA  = 2'd2,
    PG_ID   = 2'd3
  } page_e;
endpackage

// File: rtl/pgpio_data_bank.sv
module pgpio_data_bank #(
  parameter int NPORT = 6,
  parameter int BW    = 8,
  parameter int AW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [BW-1:0]       wdata,
  output logic [NPORT*BW-1:0] drive
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [BW-1:0] data_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           data_q <= '0;
      else if (wr_en && addr == AW'(p))     data_q <= wdata;
    end
    assign drive[p*BW +: BW] = data_q;

    // R2: a port byte moves only when its own offset is written
    a_r2_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == AW'(p)) |=> $stable(drive[p*BW +: BW]));
  end
endmodule

// File: rtl/pgpio_page_window.sv
module pgpio_page_window
  import pgpio_pkg::*;
#(
  parameter int NIRQ_PORT = 3,
  parameter int BW        = 8,
  parameter int AW        = 8,
  parameter int PAGE_ADDR = 7,
  localparam int WIN_BASE = PAGE_ADDR + 1,
  localparam int NW       = NIRQ_PORT * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  input  logic [NW-1:0] irq_id_in,
  output logic [BW-1:0] page_reg,
  output logic [NW-1:0] pol,
  output logic [NW-1:0] ena,
  output logic [NW-1:0] clr,
  output logic [BW-1:0] win_rdata
);
  page_e page;
  assign page = page_e'(page_reg[BW-1:BW-2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               page_reg <= '0;
    else if (wr_en && addr == AW'(PAGE_ADDR)) page_reg <= wdata;
  end

  for (genvar q = 0; q < NIRQ_PORT; q++) begin : g_slot
    logic hit;
    assign hit = wr_en && addr == AW'(WIN_BASE + q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pol[q*BW +: BW] <= '0;
        ena[q*BW +: BW] <= '0;
        clr[q*BW +: BW] <= '0;
      end else begin
        if (hit && page == PG_POL) pol[q*BW +: BW] <= wdata;
        if (hit && page == PG_ENA) ena[q*BW +: BW] <= wdata;
        clr[q*BW +: BW] <= (hit && page == PG_ID) ? wdata : '0;
      end
    end
  end

  always_comb begin
    win_rdata = '0;
    for (int q = 0; q < NIRQ_PORT; q++) begin
      if (addr == AW'(WIN_BASE + q)) begin
        case (page)
          PG_POL:  win_rdata = pol[q*BW +: BW];
          PG_ENA:  win_rdata = ena[q*BW +: BW];
          PG_ID:   win_rdata = irq_id_in[q*BW +: BW];
          default: win_rdata = '0;
        endcase
      end
    end
  end

  // R9: with page 0 selected the stored banks cannot move
  a_r9_page0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (page == PG_NONE) |=> ($stable(pol) && $stable(ena)));
  // R8: a clear pulse only follows a write made while the ID page was selected
  a_r8_clr_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |-> $past(wr_en && page == PG_ID));
  // R7: enable bits cannot change unless the enable page was selected
  a_r7_ena_page: assert property (@(posedge clk) disable iff (!rst_n)
    !(page == PG_ENA) |=> $stable(ena));
endmodule

// File: rtl/pgpio_regs.sv
module pgpio_regs #(
  parameter int NPORT     = 6,
  parameter int NIRQ_PORT = 3,
  parameter int BW        = 8,
  parameter int AW        = 8,
  localparam int SUM_ADDR  = NPORT,
  localparam int PAGE_ADDR = NPORT + 1,
  localparam int LAST_ADDR = PAGE_ADDR + NIRQ_PORT,
  localparam int NL        = NPORT * BW,
  localparam int NW        = NIRQ_PORT * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [BW-1:0] wdata,
  input  logic          rd_en,
  output logic [BW-1:0] rdata,
  input  logic [NL-1:0] pin_in,
  output logic [NL-1:0] pin_drive,
  input  logic [NW-1:0] irq_id_in,
  output logic [NW-1:0] irq_pol,
  output logic [NW-1:0] irq_ena,
  output logic [NW-1:0] irq_clr
);
  logic [BW-1:0]        page_reg;
  logic [BW-1:0]        win_rdata;
  logic [NIRQ_PORT-1:0] pend;

  pgpio_data_bank #(.NPORT(NPORT), .BW(BW), .AW(AW)) u_data (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .drive(pin_drive));

  pgpio_page_window #(.NIRQ_PORT(NIRQ_PORT), .BW(BW), .AW(AW),
                      .PAGE_ADDR(PAGE_ADDR)) u_win (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq_id_in(irq_id_in), .page_reg(page_reg), .pol(irq_pol),
    .ena(irq_ena), .clr(irq_clr), .win_rdata(win_rdata));

  for (genvar p = 0; p < NIRQ_PORT; p++) begin : g_pend
    assign pend[p] = |irq_id_in[p*BW +: BW];
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int p = 0; p < NPORT; p++)
        if (addr == AW'(p)) rdata = pin_in[p*BW +: BW];
      if (addr == AW'(SUM_ADDR))  rdata = BW'(pend);
      if (addr == AW'(PAGE_ADDR)) rdata = page_reg;
      if (addr > AW'(PAGE_ADDR) && addr <= AW'(LAST_ADDR)) rdata = win_rdata;
    end
  end

  // R4: upper summary bits are always zero
  a_r4_summary_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(SUM_ADDR)) |-> (rdata[BW-1:NIRQ_PORT] == '0));
  // R10: offsets past the map read as zero
  a_r10_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > AW'(LAST_ADDR)) |-> (rdata == '0));
  // R5: page register holds unless its offset is written
  a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(PAGE_ADDR)) |=> $stable(page_reg));
endmodule

// File: tb/sim_pgpio_regs.sv
module sim_pgpio_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = 0, wdata = 0, rdata;
  logic        wr_en = 0, rd_en = 0;
  logic [47:0] pin_in = 0, pin_drive;
  logic [23:0] irq_id_in = 0, irq_pol, irq_ena, irq_clr;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  pgpio_regs u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in),
    .pin_drive(pin_drive), .irq_id_in(irq_id_in), .irq_pol(irq_pol),
    .irq_ena(irq_ena), .irq_clr(irq_clr));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata; rd_en = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 drive", pin_drive, 0); chk("R1 pol", irq_pol, 0);
    chk("R1 ena", irq_ena, 0);     chk("R1 clr", irq_clr, 0);
    rd(8'h07, d); chk("R1 page", d, 0);
  endtask

  task automatic t_data();
    wr(8'h00, 8'hA5); wr(8'h05, 8'h3C); wr(8'h02, 8'hFF);
    chk("R2 ports", pin_drive, 48'h3C_00_00_FF_00_A5);
    wr(8'h02, 8'h0F);
    chk("R2 rewrite", pin_drive, 48'h3C_00_00_0F_00_A5);
  endtask

  task automatic t_pins();
    logic [7:0] d;
    pin_in = 48'h11_22_33_44_55_66;
    rd(8'h00, d); chk("R3 port0 live", d, 8'h66);
    rd(8'h05, d); chk("R3 port5 live", d, 8'h11);
    pin_in = 48'h0;
    rd(8'h00, d); chk("R3 follows pin", d, 8'h00);
  endtask

  task automatic t_summary();
    logic [7:0] d;
    irq_id_in = 24'h80_00_01;
    rd(8'h06, d); chk("R4 summary", d, 8'h05);
    irq_id_in = 24'h00_10_00;
    rd(8'h06, d); chk("R4 summary2", d, 8'h02);
    wr(8'h06, 8'hFF);
    chk("R4 write ignored drive", pin_drive, 48'h3C_00_00_0F_00_A5);
    rd(8'h07, d); chk("R4 write ignored page", d, 8'h00);
    irq_id_in = 0;
  endtask

  task automatic t_page_reg();
    logic [7:0] d;
    wr(8'h07, 8'h2B); rd(8'h07, d); chk("R5 readback", d, 8'h2B);
    wr(8'h08, 8'hEE); chk("R5 low bits no page", irq_pol | irq_ena, 0);
  endtask

  task automatic t_pol();
    logic [7:0] d;
    wr(8'h07, 8'h40);
    wr(8'h08, 8'h12); wr(8'h09, 8'h34); wr(8'h0A, 8'h56);
    chk("R6 pol out", irq_pol, 24'h56_34_12);
    rd(8'h09, d); chk("R6 pol read", d, 8'h34);
    chk("R6 ena untouched", irq_ena, 0);
  endtask

  task automatic t_ena();
    logic [7:0] d;
    wr(8'h07, 8'h80);
    wr(8'h08, 8'hA1); wr(8'h0A, 8'hC3);
    chk("R7 ena out", irq_ena, 24'hC3_00_A1);
    rd(8'h0A, d); chk("R7 ena read", d, 8'hC3);
    chk("R7 pol untouched", irq_pol, 24'h56_34_12);
  endtask

  task automatic t_id();
    logic [7:0] d;
    wr(8'h07, 8'hC0);
    irq_id_in = 24'h00_5A_00;
    rd(8'h09, d); chk("R8 id read", d, 8'h5A);
    @(negedge clk); addr = 8'h09; wdata = 8'h18; wr_en = 1;
    @(posedge clk); #1 chk("R8 clr pulse", irq_clr, 24'h00_18_00);
    @(negedge clk); wr_en = 0;
    @(posedge clk); #1 chk("R8 clr one cycle", irq_clr, 0);
    chk("R8 banks kept", {irq_pol, irq_ena}, {24'h56_34_12, 24'hC3_00_A1});
    irq_id_in = 0;
  endtask

  task automatic t_page0();
    logic [7:0] d;
    wr(8'h07, 8'h00);
    rd(8'h08, d); chk("R9 read zero", d, 0);
    @(negedge clk); addr = 8'h0A; wdata = 8'hFF; wr_en = 1;
    @(posedge clk); #1 chk("R9 no clr", irq_clr, 0);
    @(negedge clk); wr_en = 0;
    chk("R9 pol kept", irq_pol, 24'h56_34_12);
    chk("R9 ena kept", irq_ena, 24'hC3_00_A1);
    wr(8'h07, 8'h40); rd(8'h0A, d); chk("R9 pol via page", d, 8'h56);
  endtask

  task automatic t_oob();
    logic [7:0] d;
    pin_in = 48'hFF_FF_FF_FF_FF_FF;
    rd(8'h0B, d); chk("R10 read 0B", d, 0);
    rd(8'hFF, d); chk("R10 read FF", d, 0);
    wr(8'h0B, 8'h77); wr(8'h10, 8'h77);
    chk("R10 drive kept", pin_drive, 48'h3C_00_00_0F_00_A5);
    chk("R10 pol kept", irq_pol, 24'h56_34_12);
    rd(8'h07, d); chk("R10 page kept", d, 8'h40);
  endtask

  task automatic t_rd_gate();
    @(negedge clk); addr = 8'h00; rd_en = 0; #1;
    chk("R11 idle zero", rdata, 0);
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    t_reset();
    t_data(); t_pins(); t_summary(); t_page_reg();
    t_pol(); t_ena(); t_id(); t_page0(); t_oob(); t_rd_gate();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule